// File: doc/BRIEF.md
# IR Receive Code Buffer with Interrupt Logic

This block sits behind an infrared pulse sampler and holds the 8-bit pulse codes it produces in a first-in first-out buffer. Software drains the buffer through a small memory-mapped register port. The same port is used to set up the receiver, to choose which events raise the interrupt, and to acknowledge those events.

Three events are tracked as sticky flags: the buffer overflowing, the sampler marking the end of a packet, and the buffer fill passing a programmable trigger level. The single interrupt line is high while any flag is both set and enabled. The status register also reports the live fill count, so a handler can read the status once and then pop exactly that many codes. The buffer depth is a parameter, typically 16 or 64. The trigger level is usually set to half the depth minus one.

Top module: `ir_rx_fifo_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Offset 0x00 reads back bit 0 (global enable), bit 1 (receive enable) and bits 5:4 (mode), and reads zero elsewhere. Offset 0x10 keeps 8 configuration bits. Offset 0x34 keeps 16 sample-setup bits. Offset 0x2C keeps enable bits 0 (overflow), 1 (packet end) and 4 (data available), and a trigger level of log2(DEPTH) bits starting at bit 8.
- R3: Codes and packet-end strobes are accepted only while bits 0 and 1 of offset 0x00 are both set. Otherwise they change neither the count nor any flag.
- R4: Reading offset 0x20 returns the oldest buffered code in bits 7:0 and removes it, so codes come out in arrival order.
- R5: Reading offset 0x20 while the buffer is empty returns zero and leaves the count at zero.
- R6: Bits 8 and up of the status register at offset 0x30 hold the current fill count.
- R7: A code that arrives while the buffer is full, with no read in the same cycle, is dropped and sets status bit 0 (overflow). The count never exceeds DEPTH.
- R8: A code that arrives in the same cycle as a data read of a full buffer is stored. No overflow is flagged and the count stays at DEPTH.
- R9: An accepted packet-end strobe sets status bit 1.
- R10: Status bit 4 is set on the clock edge after a cycle in which the fill count is greater than the trigger level.
- R11: Writing ones to status bits 0, 1 and 4 clears those flags, and 0xFF clears all of them. An event that sets a flag in the same cycle wins over the clear.
- R12: `irq` is high exactly when some status flag is set and its enable bit at offset 0x2C is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_vld | input | 1 | Sampler strobe: `code` is valid |
| code | input | CODE_W | Pulse code from the sampler |
| pkt_end | input | 1 | Sampler strobe: packet finished |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at offset 0x20) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land in the same cycle. The first is a sampler push and a software pop of a full buffer. The bench fills the buffer, then raises `code_vld` and a data read on one clock. It expects no overflow flag and a count still at DEPTH, and it expects the extra code to come out last when the buffer is drained. The second pair is a write-one-to-clear and a flag-setting event. The bench issues a status clear in the same cycle as a packet-end strobe, and again while the fill stays above the trigger level, and checks that the affected flag reads back set.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
    localparam logic [5:0] OFF_CTRL  = 6'h00;
    localparam logic [5:0] OFF_RXCFG = 6'h10;
    localparam logic [5:0] OFF_DATA  = 6'h20;
    localparam logic [5:0] OFF_IEN   = 6'h2C;
    localparam logic [5:0] OFF_STAT  = 6'h30;
    localparam logic [5:0] OFF_SAMP  = 6'h34;

    localparam int BIT_OVF   = 0;
    localparam int BIT_PEND  = 1;
    localparam int BIT_AVAIL = 4;
    localparam int FIELD_LSB = 8;

    typedef struct packed {
        logic avail;
        logic pend;
        logic ovf;
    } evt_flags_t;
endpackage

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
    parameter int DEPTH  = 16,
    parameter int CODE_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [CODE_W-1:0] push_code,
    input  logic              pop,
    output logic [CODE_W-1:0] pop_code,
    output logic [CNT_W-1:0]  count,
    output logic              drop
);
    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [CODE_W-1:0] mem_q [DEPTH];
    logic full, empty, do_pop, do_push;

    always_comb begin
        full    = (st_q.cnt == CNT_W'(DEPTH));
        empty   = (st_q.cnt == '0);
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        drop    = push && full && !do_pop;
        st_d    = st_q;
        if (do_push)
            st_d.wptr = (st_q.wptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
        if (do_pop)
            st_d.rptr = (st_q.rptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        pop_code = empty ? '0 : mem_q[st_q.rptr];
        count    = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wptr] <= push_code;
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R5
    empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == '0 && !push) |=> count == '0);
    // R8
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && count == CNT_W'(DEPTH)) |=> count == CNT_W'(DEPTH));
endmodule

// File: rtl/ir_rx_flags.sv
module ir_rx_flags
    import ir_rx_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop,
    input  logic             pkt_end,
    input  logic [CNT_W-1:0] count,
    input  logic [LVL_W-1:0] level,
    input  evt_flags_t       clr,
    input  evt_flags_t       ena,
    output evt_flags_t       flags,
    output logic             irq
);
    evt_flags_t flg_d, flg_q;
    logic above;

    always_comb begin
        above       = count > CNT_W'(level);
        flg_d.ovf   = (flg_q.ovf   & ~clr.ovf)   | drop;
        flg_d.pend  = (flg_q.pend  & ~clr.pend)  | pkt_end;
        flg_d.avail = (flg_q.avail & ~clr.avail) | above;
        flags       = flg_q;
        irq         = |(flg_q & ena);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> flags.ovf);
    // R9
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> flags.pend);
    // R12
    irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && ena.pend) |=> (irq || !$past(ena.pend) || !ena.pend));
    // R11
    ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr.ovf && !drop) |=> !flags.ovf);
endmodule

// File: rtl/ir_rx_fifo_ctrl.sv
module ir_rx_fifo_ctrl
    import ir_rx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_vld,
    input  logic [CODE_W-1:0] code,
    input  logic              pkt_end,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int LVL_W = $clog2(DEPTH);

    typedef struct packed {
        logic             gen;
        logic             rxen;
        logic [1:0]       mode;
        logic [7:0]       rxcfg;
        logic [15:0]      samp;
        evt_flags_t       ena;
        logic [LVL_W-1:0] level;
    } regs_t;

    regs_t rg_d, rg_q;
    logic accept, push, pend_in, pop;
    evt_flags_t clr, flags;
    logic [CODE_W-1:0] pop_code;
    logic [CNT_W-1:0]  count;
    logic drop;

    always_comb begin
        accept  = rg_q.gen && rg_q.rxen;
        push    = code_vld && accept;
        pend_in = pkt_end && accept;
        pop     = reg_rd && (reg_addr == OFF_DATA);
        clr     = '0;
        rg_d    = rg_q;
        if (reg_wr) begin
            case (reg_addr)
                OFF_CTRL: begin
                    rg_d.gen  = reg_wdata[0];
                    rg_d.rxen = reg_wdata[1];
                    rg_d.mode = reg_wdata[5:4];
                end
                OFF_RXCFG: rg_d.rxcfg = reg_wdata[7:0];
                OFF_SAMP:  rg_d.samp  = reg_wdata[15:0];
                OFF_IEN: begin
                    rg_d.ena.ovf   = reg_wdata[BIT_OVF];
                    rg_d.ena.pend  = reg_wdata[BIT_PEND];
                    rg_d.ena.avail = reg_wdata[BIT_AVAIL];
                    rg_d.level     = reg_wdata[FIELD_LSB +: LVL_W];
                end
                OFF_STAT: begin
                    clr.ovf   = reg_wdata[BIT_OVF];
                    clr.pend  = reg_wdata[BIT_PEND];
                    clr.avail = reg_wdata[BIT_AVAIL];
                end
                default: ;
            endcase
        end
        reg_rdata = '0;
        case (reg_addr)
            OFF_CTRL: begin
                reg_rdata[0]   = rg_q.gen;
                reg_rdata[1]   = rg_q.rxen;
                reg_rdata[5:4] = rg_q.mode;
            end
            OFF_RXCFG: reg_rdata[7:0]  = rg_q.rxcfg;
            OFF_SAMP:  reg_rdata[15:0] = rg_q.samp;
            OFF_DATA:  reg_rdata[CODE_W-1:0] = pop_code;
            OFF_IEN: begin
                reg_rdata[BIT_OVF]   = rg_q.ena.ovf;
                reg_rdata[BIT_PEND]  = rg_q.ena.pend;
                reg_rdata[BIT_AVAIL] = rg_q.ena.avail;
                reg_rdata[FIELD_LSB +: LVL_W] = rg_q.level;
            end
            OFF_STAT: begin
                reg_rdata[BIT_OVF]   = flags.ovf;
                reg_rdata[BIT_PEND]  = flags.pend;
                reg_rdata[BIT_AVAIL] = flags.avail;
                reg_rdata[FIELD_LSB +: CNT_W] = count;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    ir_rx_fifo #(.DEPTH(DEPTH), .CODE_W(CODE_W)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_code(code),
        .pop(pop), .pop_code(pop_code), .count(count), .drop(drop)
    );

    ir_rx_flags #(.CNT_W(CNT_W), .LVL_W(LVL_W)) i_flags (
        .clk(clk), .rst_n(rst_n), .drop(drop), .pkt_end(pend_in),
        .count(count), .level(rg_q.level), .clr(clr), .ena(rg_q.ena),
        .flags(flags), .irq(irq)
    );

    // R3
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && !accept && !pop) |=> $stable(count));
endmodule

// File: tb/test_ir_rx_fifo_ctrl.sv
module test_ir_rx_fifo_ctrl;
    localparam int DEPTH = 16;
    localparam logic [5:0] A_CTRL = 6'h00, A_RXCFG = 6'h10, A_DATA = 6'h20,
                           A_IEN = 6'h2C, A_STAT = 6'h30, A_SAMP = 6'h34;

    logic clk = 0, rst_n = 0;
    logic code_vld = 0, pkt_end = 0, reg_wr = 0, reg_rd = 0;
    logic [7:0]  code = 0;
    logic [5:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic irq;
    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    ir_rx_fifo_ctrl #(.DEPTH(DEPTH), .CODE_W(8)) i_ir_rx_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .code_vld(code_vld), .code(code),
        .pkt_end(pkt_end), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1 reg_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 v = reg_rdata;
        @(posedge clk); #1 reg_rd = 0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic push(input logic [7:0] c);
        @(negedge clk); code_vld = 1; code = c;
        @(posedge clk); #1 code_vld = 0;
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        rd_chk("R1 status", A_STAT, 0);
        rd_chk("R1 ctrl", A_CTRL, 0);
        rd_chk("R1 enable", A_IEN, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_config();
        wr(A_CTRL, 32'h33);        rd_chk("R2 ctrl", A_CTRL, 32'h33);
        wr(A_CTRL, 32'hFFFF_FFFF); rd_chk("R2 ctrl mask", A_CTRL, 32'h33);
        wr(A_RXCFG, 32'h1234);     rd_chk("R2 rxcfg", A_RXCFG, 32'h34);
        wr(A_SAMP, 32'h1234_5678); rd_chk("R2 samp", A_SAMP, 32'h5678);
        wr(A_IEN, 32'hFFFF_FFFF);  rd_chk("R2 ien", A_IEN, 32'hF13);
        wr(A_IEN, 0);
        wr(A_CTRL, 0);
    endtask

    task automatic t_gate();
        wr(A_IEN, 32'hF00);
        wr(A_CTRL, 32'h01);
        push(8'hAA);
        @(negedge clk); pkt_end = 1; @(posedge clk); #1 pkt_end = 0;
        idle();
        rd_chk("R3 gated status", A_STAT, 0);
    endtask

    task automatic t_order();
        wr(A_CTRL, 32'h03);
        push(8'h11); push(8'h22); push(8'h83);
        rd_chk("R6 count 3", A_STAT, 32'h300);
        rd_chk("R4 first", A_DATA, 32'h11);
        rd_chk("R4 second", A_DATA, 32'h22);
        rd_chk("R4 third", A_DATA, 32'h83);
        rd_chk("R6 count 0", A_STAT, 0);
    endtask

    task automatic t_empty();
        rd_chk("R5 empty data", A_DATA, 0);
        rd_chk("R5 empty count", A_STAT, 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i <= DEPTH; i++) push(8'(i + 1));
        rd_chk("R7 overflow status", A_STAT, 32'h1011);
        chk("R12 irq masked", {31'b0, irq}, 0);
        wr(A_IEN, 32'hF01);
        chk("R12 irq ovf", {31'b0, irq}, 1);
        rd_chk("R7 oldest kept", A_DATA, 32'h01);
        wr(A_STAT, 32'h01);
        rd_chk("R11 ovf cleared", A_STAT, 32'hF10);
        chk("R12 irq low", {31'b0, irq}, 0);
        wr(A_STAT, 32'hFF);
        rd_chk("R11 clear all", A_STAT, 32'hF00);
        for (int i = 2; i <= DEPTH; i++) rd_chk("R4 drain", A_DATA, 32'(i));
        wr(A_IEN, 32'hF00);
    endtask

    task automatic t_level();
        wr(A_IEN, 32'h710);
        for (int i = 0; i < 7; i++) push(8'h40);
        idle();
        rd_chk("R10 at level", A_STAT, 32'h700);
        chk("R12 irq below", {31'b0, irq}, 0);
        push(8'h41);
        idle();
        rd_chk("R10 above level", A_STAT, 32'h810);
        chk("R12 irq avail", {31'b0, irq}, 1);
        wr(A_STAT, 32'h10);
        rd_chk("R11 set wins avail", A_STAT, 32'h810);
        for (int i = 0; i < 8; i++) rd_chk("R4 drain level", A_DATA, (i == 7) ? 32'h41 : 32'h40);
        wr(A_STAT, 32'hFF);
        wr(A_IEN, 32'hF02);
    endtask

    task automatic t_pend();
        @(negedge clk); pkt_end = 1; @(posedge clk); #1 pkt_end = 0;
        rd_chk("R9 packet end", A_STAT, 32'h002);
        chk("R12 irq pend", {31'b0, irq}, 1);
        @(negedge clk); pkt_end = 1; reg_wr = 1; reg_addr = A_STAT; reg_wdata = 32'h02;
        @(posedge clk); #1 pkt_end = 0; reg_wr = 0;
        rd_chk("R11 set wins pend", A_STAT, 32'h002);
        wr(A_STAT, 32'h02);
        rd_chk("R11 pend cleared", A_STAT, 0);
        chk("R12 irq cleared", {31'b0, irq}, 0);
    endtask

    task automatic t_swap();
        logic [31:0] v;
        wr(A_IEN, 32'hF01);
        for (int i = 0; i < DEPTH; i++) push(8'(8'h80 + i));
        wr(A_STAT, 32'hFF);
        @(negedge clk); code_vld = 1; code = 8'h5A; reg_rd = 1; reg_addr = A_DATA;
        #1 v = reg_rdata;
        @(posedge clk); #1 code_vld = 0; reg_rd = 0;
        chk("R8 swap pops oldest", v, 32'h80);
        rd_chk("R8 no overflow", A_STAT, 32'h1010);
        chk("R8 irq low", {31'b0, irq}, 0);
        for (int i = 1; i < DEPTH; i++) rd(A_DATA, v);
        rd_chk("R8 pushed code last", A_DATA, 32'h5A);
        rd_chk("R6 empty after", A_STAT, 32'h010);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_config();
        t_gate();
        t_order();
        t_empty();
        t_overflow();
        t_level();
        t_pend();
        t_swap();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule